// File: doc/BRIEF.md
# Character-Addressed Word Store with Parity

This block serves a requester that works in single characters while the storage behind it is organised in wide words. A character is seven bits: six data bits and one odd-parity bit. Four characters share one 28-bit word. The requester presents a character address with a read or a write, and the block always moves the whole word that holds that character. A read returns the six data bits of the addressed character and reports whether its stored parity is wrong. A write reads the word, replaces one character with the new data and a freshly generated parity bit, and writes the full word back.

The storage is an internal word array whose capacity is a parameter. Addresses past the end of the array are refused with an address-error response, and the array is not touched. Only one request is in flight at a time. A busy flag and the inverse ready signal hold off new requests until the response cycle.

Top module: `chw_mem`

## Requirements
- R1: A character address splits into a word index (address divided by four) and a slot (address modulo four). Slot 0 occupies word bits 27:21, slot 1 bits 20:14, slot 2 bits 13:7 and slot 3 bits 6:0. Four distinct characters written to one word read back independently.
- R2: A stored character holds its data in bits 6:1 and its parity in bit 0. The parity bit is generated on every write so that the seven bits hold an odd number of ones, and a character written through the block reads back with `rsp_perr` = 0.
- R3: A read response carries the six data bits of the addressed character on `rsp_data`. `rsp_perr` is 1 exactly when the stored seven bits hold an even number of ones. `rsp_perr` is only ever high together with `rsp_valid`.
- R4: A write is a read-modify-write of the containing word. The other three characters of that word keep their stored values. The write response has `rsp_data` = 0, `rsp_perr` = 0 and `rsp_aerr` = 0.
- R5: The array starts as all zeros. A character that was never written therefore reads as data 0 with `rsp_perr` = 1.
- R6: A request whose word index is not below the word capacity (default 64 words, so character addresses 256 and above) returns `rsp_aerr` = 1 with `rsp_data` = 0. It performs no array access, so a refused write changes no stored character, including the word that its truncated index would alias.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is the inverse of `busy`. `busy` is high from the cycle after acceptance until the response cycle. A request offered while `busy` is high is ignored.
- R8: `rsp_valid` is a single-cycle pulse. It is high in the third cycle after the accepting edge for an in-range request and in the second cycle for an out-of-range request.
- R9: Synchronous reset clears `busy`, `rsp_valid`, `rsp_perr` and `rsp_aerr` and raises `req_ready`, but leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write character, 0 = read character |
| req_addr | input | ADDR_W (10) | Character address |
| req_data | input | DATA_W (6) | Character data for writes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W (6) | Data bits of the read character |
| rsp_perr | output | 1 | Stored parity of the read character is wrong |
| rsp_aerr | output | 1 | Address beyond capacity; request refused |
| busy | output | 1 | A request is in progress |

## Verification
A parity error cannot be planted through the ports, because every write generates correct parity. The bench therefore relies on the all-zero starting content: it reads characters that were never written, including neighbours of a freshly written slot, so each parity-error read also shows that the merge left those slots alone. The out-of-range write is aimed at an address whose truncated word index aliases word 0, and a later read of word 0 shows that nothing landed there.

// File: rtl/chw_pkg.sv
package chw_pkg;

  // Sequencer states for one character request
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_FAULT = 2'd3
  } chw_state_t;

  // Default geometry shared by the modules
  localparam int CHW_DATA_W = 6;
  localparam int CHW_SLOTS  = 4;

endpackage

// File: rtl/chw_slot.sv
module chw_slot #(
  parameter int DATA_W = chw_pkg::CHW_DATA_W,
  parameter int SLOTS  = chw_pkg::CHW_SLOTS,
  localparam int CHAR_W = DATA_W + 1,
  localparam int WORD_W = CHAR_W * SLOTS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] new_data,
  output logic [CHAR_W-1:0] sel_char,
  output logic [WORD_W-1:0] word_out
);

  logic [CHAR_W-1:0] new_char;
  logic [CHAR_W-1:0] chars [SLOTS];

  // Odd parity in the low bit: XNOR-reduce makes the total count odd
  assign new_char = {new_data, ~^new_data};

  // Slot 0 sits at the most significant end of the word
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam int HI = WORD_W - 1 - i * CHAR_W;
    assign chars[i] = word_in[HI -: CHAR_W];
    assign word_out[HI -: CHAR_W] = (slot == SLOT_W'(i)) ? new_char : chars[i];
  end

  assign sel_char = chars[slot];

endmodule

// File: rtl/chw_array.sv
module chw_array #(
  parameter int WORDS  = 64,
  parameter int WIDTH  = 28,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  // No reset on the storage so a block RAM can hold it; starts at zero
  logic [WIDTH-1:0] mem [WORDS] = '{default: '0};

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  // R4: every write-back follows a read of the same word one cycle earlier
  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(rd_en) && $past(addr) == addr));

  // R7: read and write never share a cycle in a single-request sequencer
  a_r7_single_access: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

endmodule

// File: rtl/chw_ctrl.sv
module chw_ctrl #(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 10,
  parameter int DATA_W = chw_pkg::CHW_DATA_W,
  parameter int SLOTS  = chw_pkg::CHW_SLOTS,
  localparam int CHAR_W  = DATA_W + 1,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int WADDR_W = ADDR_W - SLOT_W,
  localparam int AW      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              arr_rd_en,
  output logic              arr_wr_en,
  output logic [AW-1:0]     arr_addr,
  output logic [SLOT_W-1:0] slot_sel,
  output logic [DATA_W-1:0] wr_data,
  input  logic [CHAR_W-1:0] sel_char,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_perr,
  output logic              rsp_aerr
);
  import chw_pkg::*;

  localparam logic [WADDR_W:0] LIMIT = (WADDR_W + 1)'(WORDS);

  chw_state_t         state_q;
  logic               we_q;
  logic [WADDR_W-1:0] word_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [DATA_W-1:0]  data_q;
  logic               accept;
  logic [WADDR_W-1:0] req_word;
  logic               in_range;

  assign busy      = (state_q != ST_IDLE);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign req_word  = req_addr[ADDR_W-1:SLOT_W];
  assign in_range  = ({1'b0, req_word} < LIMIT);

  assign arr_rd_en = (state_q == ST_READ);
  assign arr_wr_en = (state_q == ST_MERGE) & we_q;
  assign arr_addr  = word_q[AW-1:0];
  assign slot_sel  = slot_q;
  assign wr_data   = data_q;

  // Request capture
  always_ff @(posedge clk) begin
    if (accept) begin
      we_q   <= req_we;
      word_q <= req_word;
      slot_q <= req_addr[SLOT_W-1:0];
      data_q <= req_data;
    end
  end

  // Sequencer and registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_perr  <= 1'b0;
      rsp_aerr  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_perr  <= 1'b0;
      rsp_aerr  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) state_q <= in_range ? ST_READ : ST_FAULT;
        end
        ST_READ: begin
          state_q <= ST_MERGE;
        end
        ST_MERGE: begin
          rsp_valid <= 1'b1;
          if (we_q) begin
            rsp_data <= '0;
          end else begin
            rsp_data <= sel_char[CHAR_W-1:1];
            rsp_perr <= ~(^sel_char);
          end
          state_q <= ST_IDLE;
        end
        ST_FAULT: begin
          rsp_valid <= 1'b1;
          rsp_aerr  <= 1'b1;
          rsp_data  <= '0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: an accepted request makes the block busy on the next cycle
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R8: the response strobe lasts one cycle
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8: the response cycle finds the block idle again
  a_r8_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R3: a parity flag only accompanies an in-range response
  a_r3_perr_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_perr |-> (rsp_valid && !rsp_aerr));

  // R6: the array is only driven with an index inside capacity
  a_r6_index_in_range: assert property (@(posedge clk) disable iff (rst)
    (arr_rd_en || arr_wr_en) |-> ({1'b0, word_q} < LIMIT));

endmodule

// File: rtl/chw_mem.sv
module chw_mem #(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 10,
  parameter int DATA_W = chw_pkg::CHW_DATA_W,
  parameter int SLOTS  = chw_pkg::CHW_SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_perr,
  output logic              rsp_aerr,
  output logic              busy
);

  localparam int CHAR_W = DATA_W + 1;
  localparam int WORD_W = CHAR_W * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int AW     = $clog2(WORDS);

  logic              arr_rd_en;
  logic              arr_wr_en;
  logic [AW-1:0]     arr_addr;
  logic [WORD_W-1:0] arr_rdata;
  logic [WORD_W-1:0] arr_wdata;
  logic [SLOT_W-1:0] slot_sel;
  logic [DATA_W-1:0] wr_data;
  logic [CHAR_W-1:0] sel_char;

  chw_ctrl #(
    .WORDS (WORDS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SLOTS (SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_ready(req_ready),
    .busy     (busy),
    .arr_rd_en(arr_rd_en),
    .arr_wr_en(arr_wr_en),
    .arr_addr (arr_addr),
    .slot_sel (slot_sel),
    .wr_data  (wr_data),
    .sel_char (sel_char),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_perr (rsp_perr),
    .rsp_aerr (rsp_aerr)
  );

  chw_slot #(
    .DATA_W(DATA_W),
    .SLOTS (SLOTS)
  ) u_slot (
    .word_in (arr_rdata),
    .slot    (slot_sel),
    .new_data(wr_data),
    .sel_char(sel_char),
    .word_out(arr_wdata)
  );

  chw_array #(
    .WORDS(WORDS),
    .WIDTH(WORD_W)
  ) u_array (
    .clk  (clk),
    .rst  (rst),
    .rd_en(arr_rd_en),
    .wr_en(arr_wr_en),
    .addr (arr_addr),
    .wdata(arr_wdata),
    .rdata(arr_rdata)
  );

  // R6: a refused request leaves the array untouched in the cycle before it
  a_r6_fault_no_access: assert property (@(posedge clk) disable iff (rst)
    rsp_aerr |-> (!$past(arr_rd_en) && !$past(arr_wr_en)));

  // R2: the word written back carries odd parity in the replaced slot
  a_r2_written_parity: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |-> ^arr_wdata[WORD_W-1 - int'(slot_sel) * CHAR_W -: CHAR_W]);

endmodule

// File: tb/chw_mem_tb.sv
`timescale 1ns/1ps
module chw_mem_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_we = 1'b0;
  logic [9:0] req_addr = '0;
  logic [5:0] req_data = '0;
  logic       rsp_valid;
  logic [5:0] rsp_data;
  logic       rsp_perr;
  logic       rsp_aerr;
  logic       busy;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  chw_mem u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_perr(rsp_perr),
    .rsp_aerr(rsp_aerr), .busy(busy)
  );

  // Vector: {we, addr, data, exp_data, exp_perr, exp_aerr}
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 10'd5,    6'h00, 6'h00, 1'b1, 1'b0},  // R5 unwritten
    {1'b1, 10'd5,    6'h2A, 6'h00, 1'b0, 1'b0},
    {1'b0, 10'd5,    6'h00, 6'h2A, 1'b0, 1'b0},
    {1'b0, 10'd4,    6'h00, 6'h00, 1'b1, 1'b0},  // R4 neighbour kept
    {1'b0, 10'd6,    6'h00, 6'h00, 1'b1, 1'b0},
    {1'b1, 10'd4,    6'h3F, 6'h00, 1'b0, 1'b0},
    {1'b1, 10'd7,    6'h00, 6'h00, 1'b0, 1'b0},
    {1'b0, 10'd4,    6'h00, 6'h3F, 1'b0, 1'b0},
    {1'b0, 10'd5,    6'h00, 6'h2A, 1'b0, 1'b0},
    {1'b0, 10'd7,    6'h00, 6'h00, 1'b0, 1'b0},  // R2 zero data, odd parity
    {1'b1, 10'd255,  6'h15, 6'h00, 1'b0, 1'b0},  // last in-range char
    {1'b0, 10'd255,  6'h00, 6'h15, 1'b0, 1'b0},
    {1'b1, 10'd256,  6'h11, 6'h00, 1'b0, 1'b1},  // R6 aliases word 0
    {1'b0, 10'd0,    6'h00, 6'h00, 1'b1, 1'b0},
    {1'b0, 10'd1023, 6'h00, 6'h00, 1'b0, 1'b1},
    {1'b1, 10'd6,    6'h01, 6'h00, 1'b0, 1'b0},
    {1'b0, 10'd6,    6'h00, 6'h01, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [9:0] a, input logic [5:0] d,
                        output logic [5:0] got, output logic pe, output logic ae,
                        output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end while (!rsp_valid && lat < 20);
    got = rsp_data; pe = rsp_perr; ae = rsp_aerr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] got;
    logic pe, ae;
    int lat;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 busy in reset", busy, 0);
    chk("R9 ready in reset", req_ready, 1);
    chk("R9 rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic        vwe;
      logic [9:0]  va;
      logic [5:0]  vd, ed;
      logic        ep, ea;
      {vwe, va, vd, ed, ep, ea} = VEC[i];
      do_req(vwe, va, vd, got, pe, ae, lat);
      chk("R6 aerr", ae, ea);
      chk(ea ? "R6 data" : (vwe ? "R4 write ack data" : "R3 read data"), got, ed);
      chk(ep ? "R5 perr" : "R2 perr", pe, ep);
      chk("R8 latency", lat, ea ? 2 : 3);
    end

    // R1 four slots of one word
    for (int s = 0; s < 4; s++) do_req(1'b1, 10'(40 + s), 6'(6'h09 * (s + 1)), got, pe, ae, lat);
    for (int s = 0; s < 4; s++) begin
      do_req(1'b0, 10'(40 + s), 6'h00, got, pe, ae, lat);
      chk("R1 slot data", got, 6'(6'h09 * (s + 1)));
      chk("R1 slot perr", pe, 0);
    end

    // R7 request offered while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 10'd5; req_data = 6'h00;
    @(posedge clk);
    @(negedge clk);
    chk("R7 busy after accept", busy, 1);
    chk("R7 ready low", req_ready, 0);
    req_we = 1'b1; req_addr = 10'd5; req_data = 6'h00;
    @(negedge clk);
    chk("R8 no early rsp", rsp_valid, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 rsp cycle", rsp_valid, 1);
    chk("R7 rsp cycle not busy", busy, 0);
    chk("R3 read during R7", rsp_data, 6'h2A);
    @(negedge clk);
    chk("R8 single pulse", rsp_valid, 0);
    chk("R7 no second request", busy, 0);
    do_req(1'b0, 10'd5, 6'h00, got, pe, ae, lat);
    chk("R7 ignored write", got, 6'h2A);

    // R9 reset keeps array, clears in-flight request
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 10'd4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 busy cleared", busy, 0);
    chk("R9 rsp cleared", rsp_valid, 0);
    rst = 1'b0;
    do_req(1'b0, 10'd4, 6'h00, got, pe, ae, lat);
    chk("R9 array kept", got, 6'h3F);
    chk("R9 array kept perr", pe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule